// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Write Sequencer

This block sits behind a processor's I/O register space and controls a small byte-wide nonvolatile data store. Software sees three registers: a 7-bit location register, an 8-bit data register and an 8-bit control register. Reads complete in a single clock. A write is a timed operation. Software must first set an arming bit in the control register. Within a short window after that, it must set the start bit. The start bit then reads back as one for as long as the write lasts, so software polls it to see when the store is free again.

The storage array is modelled as a register memory. Its programming time is a parameter counted in clocks. If software rewrites the location or data register while a write is running, the write is abandoned. The targeted byte is then left in an undefined state, which the model represents as 0xFF, the same value as an erased cell.

Top module: `eectl_top`

## Requirements
- R1: After synchronous reset the location register, the data register and the control register all read 0, and every array location reads 0xFF.
- R2: Control register bits 7 to 3 always read 0, whatever value is written. Bit 2 is the arming bit, bit 1 is the write start/busy bit and bit 0 is the read strobe bit.
- R3: A control write with bit 2 set makes bit 2 read 1 for exactly ARM_WIN clocks, after which it clears by itself.
- R4: A write starts only when a control write with bit 1 set arrives while bit 2 already reads 1 and no write is running. Starting a write clears bit 2. If bit 1 is written while bit 2 reads 0, nothing starts. This includes the case where the same control write also sets bit 2.
- R5: Once a write starts, bit 1 reads 1 for exactly WR_CYCLES clocks. Afterwards, the location that was in the location register at the start holds the byte that was in the data register at the start.
- R6: When no write is running, a control write with bit 0 set loads the data register from the addressed location on the same edge. Bit 0 then reads 1 for that one clock only.
- R7: A read strobe issued while a write is running has no effect: the data register is unchanged and bit 0 stays 0.
- R8: A write to the location or data register while a write is running aborts that write. Bit 1 reads 0 on the next clock, the targeted location reads 0xFF, and the register takes the newly written value.
- R9: The location register keeps only the low 7 bits of a written byte, so it covers locations 0x00 to 0x7F, and location 0x7F can be written and read.
- R10: A control write with bit 1 set while a write is running neither restarts nor lengthens that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe from the processor |
| reg_sel | input | 2 | Register select: 0 location, 1 data, 2 control, 3 none |
| reg_wdata | input | 8 | Byte written to the selected register |
| addr_out | output | ADDR_W | Location register contents |
| data_out | output | 8 | Data register contents |
| ctrl_out | output | 8 | Control register read value |

## Verification
The bench builds the block with WR_CYCLES set to 6 and with the defaults ADDR_W of 7 and ARM_WIN of 4. A programming time this short lets several complete writes run, along with an abort part-way through a write, a read strobe and a second start issued while a write is busy, all within a short run. Keeping the full 7-bit location space brings the top location 0x7F and the dropped eighth address bit within reach. The arming window of 4 is short enough to let it expire between two register writes.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } eectl_sel_e;

    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_ARM = 2;

    localparam logic [7:0] ERASED = 8'hFF;

    typedef struct packed {
        logic we;
        eectl_sel_e sel;
        logic [7:0] wdata;
    } eectl_req_t;

    typedef struct packed {
        logic arm;
        logic busy;
        logic rd;
    } eectl_stat_t;

    function automatic logic [7:0] pack_ctrl(eectl_stat_t s);
        return {5'b00000, s.arm, s.busy, s.rd};
    endfunction

endpackage

// File: rtl/eectl_arm.sv
module eectl_arm #(
    parameter int ARM_WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic live
);
    localparam int CW = $clog2(ARM_WIN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr_req)
            cnt <= '0;
        else if (set_req)
            cnt <= CW'(ARM_WIN);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign live = (cnt != '0);

    // R3
    arm_window_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(ARM_WIN));

    // R3
    arm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(live) |-> $past(set_req));

endmodule

// File: rtl/eectl_wseq.sv
module eectl_wseq
    import eectl_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WR_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              touch,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              busy,
    output logic              cm_en,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [7:0]        cm_data
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic              busy_q;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              last;

    assign last    = (cnt == CW'(1));
    assign busy    = busy_q;
    assign cm_en   = busy_q && (touch || last);
    assign cm_addr = tgt_addr;
    assign cm_data = touch ? ERASED : tgt_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else if (busy_q) begin
            if (touch || last) begin
                busy_q <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (go) begin
            busy_q   <= 1'b1;
            cnt      <= CW'(WR_CYCLES);
            tgt_addr <= addr_in;
            tgt_data <= data_in;
        end
    end

    // R5
    busy_span_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt != '0 && cnt <= CW'(WR_CYCLES)));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && touch) |=> !busy_q);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last && !touch) |=> (busy_q && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/eectl_array.sv
module eectl_array
    import eectl_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ERASED;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eectl_regs.sv
module eectl_regs #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_data,
    input  logic              ld_rd,
    input  logic [7:0]        wdata,
    input  logic [7:0]        rd_value,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (ld_addr)
                addr_q <= wdata[ADDR_W-1:0];
            if (ld_data)
                data_q <= wdata;
            else if (ld_rd)
                data_q <= rd_value;
        end
    end

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_data && !ld_rd) |=> $stable(data_q));

endmodule

// File: rtl/eectl_top.sv
module eectl_top
    import eectl_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WR_CYCLES = 32,
    parameter int ARM_WIN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic [7:0]        data_out,
    output logic [7:0]        ctrl_out
);
    eectl_req_t  req;
    eectl_stat_t stat;

    logic we_addr, we_data, we_ctrl, touch;
    logic arm_live, busy, go, rd_go, rd_flag;
    logic cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [7:0] cm_data, mem_rdata;

    assign req.we    = reg_we;
    assign req.sel   = eectl_sel_e'(reg_sel);
    assign req.wdata = reg_wdata;

    assign we_addr = req.we && (req.sel == SEL_ADDR);
    assign we_data = req.we && (req.sel == SEL_DATA);
    assign we_ctrl = req.we && (req.sel == SEL_CTRL);
    assign touch   = we_addr || we_data;

    assign go    = we_ctrl && req.wdata[CB_WR] && arm_live && !busy;
    assign rd_go = we_ctrl && req.wdata[CB_RD] && !busy && !go;

    eectl_arm #(.ARM_WIN(ARM_WIN)) u_arm (
        .clk     (clk),
        .rst     (rst),
        .set_req (we_ctrl && req.wdata[CB_ARM]),
        .clr_req (go),
        .live    (arm_live)
    );

    eectl_wseq #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_wseq (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .touch   (touch),
        .addr_in (addr_out),
        .data_in (data_out),
        .busy    (busy),
        .cm_en   (cm_en),
        .cm_addr (cm_addr),
        .cm_data (cm_data)
    );

    eectl_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_en),
        .waddr (cm_addr),
        .wdata (cm_data),
        .raddr (addr_out),
        .rdata (mem_rdata)
    );

    eectl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ld_addr  (we_addr),
        .ld_data  (we_data),
        .ld_rd    (rd_go),
        .wdata    (req.wdata),
        .rd_value (mem_rdata),
        .addr_q   (addr_out),
        .data_q   (data_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_flag <= 1'b0;
        else
            rd_flag <= rd_go;
    end

    assign stat.arm  = arm_live;
    assign stat.busy = busy;
    assign stat.rd   = rd_flag;
    assign ctrl_out  = pack_ctrl(stat);

    // R6
    rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_flag |-> !busy);

    // R4
    start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm_live));

    // R4
    start_clears_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !arm_live);

endmodule

// File: tb/sim_eectl_top.sv
module sim_eectl_top;
    localparam int AW  = 7;
    localparam int WRC = 6;
    localparam int ARW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [AW-1:0] addr_out;
    logic [7:0] data_out, ctrl_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eectl_top #(.ADDR_W(AW), .WR_CYCLES(WRC), .ARM_WIN(ARW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_out(addr_out), .data_out(data_out),
        .ctrl_out(ctrl_out)
    );

    // behavioural reference model
    int m_mem [128];
    int m_addr, m_data, m_arm, m_busy, m_tgt, m_tdat;
    bit m_rd;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            m_addr = 0; m_data = 0; m_arm = 0; m_busy = 0;
            m_tgt = 0; m_tdat = 0; m_rd = 0;
        end else begin
            bit touch, wctl, start, rd;
            int old_rd;
            touch  = reg_we && (reg_sel == 2'd0 || reg_sel == 2'd1);
            wctl   = reg_we && reg_sel == 2'd2;
            start  = wctl && reg_wdata[1] && m_arm > 0 && m_busy == 0;
            rd     = wctl && reg_wdata[0] && m_busy == 0 && !start;
            old_rd = m_mem[m_addr];
            if (m_busy > 0) begin
                if (touch) begin m_mem[m_tgt] = 255; m_busy = 0; end
                else if (m_busy == 1) begin m_mem[m_tgt] = m_tdat; m_busy = 0; end
                else m_busy--;
            end else if (start) begin
                m_busy = WRC; m_tgt = m_addr; m_tdat = m_data;
            end
            if (start) m_arm = 0;
            else if (wctl && reg_wdata[2]) m_arm = ARW;
            else if (m_arm > 0) m_arm--;
            m_rd = rd;
            if (reg_we && reg_sel == 2'd0) m_addr = reg_wdata & 8'h7F;
            if (reg_we && reg_sel == 2'd1) m_data = reg_wdata;
            else if (rd) m_data = old_rd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 reserved bits", int'(ctrl_out[7:3]), 0);
            chk("R3 arm bit", int'(ctrl_out[2]), int'(m_arm > 0));
            chk("R5 busy bit", int'(ctrl_out[1]), int'(m_busy > 0));
            chk("R6 read bit", int'(ctrl_out[0]), int'(m_rd));
            chk("R9 location register", int'(addr_out), m_addr);
            chk("R6 R8 data register", int'(data_out), m_data);
        end
    end

    task automatic put(input logic [1:0] s, input logic [7:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 2'd3; reg_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_loc(input logic [7:0] a, input int exp, input string tag);
        put(2'd0, a);
        put(2'd2, 8'h01);
        chk(tag, int'(data_out), exp);
    endtask

    task automatic finish_up();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl after reset", int'(ctrl_out), 0);
        chk("R1 location after reset", int'(addr_out), 0);
        chk("R1 data after reset", int'(data_out), 0);
        rd_loc(8'h7F, 8'hFF, "R1 erased location");

        // R9 eighth address bit dropped
        put(2'd0, 8'h85);
        chk("R9 address truncation", int'(addr_out), 8'h05);

        // R3 R4 R5 normal armed write
        put(2'd1, 8'h3C);
        put(2'd2, 8'h04);
        chk("R3 arm set", int'(ctrl_out[2]), 1);
        put(2'd2, 8'h02);
        chk("R4 write started", int'(ctrl_out[1]), 1);
        chk("R4 arm cleared by start", int'(ctrl_out[2]), 0);
        idle(WRC);
        chk("R5 write finished", int'(ctrl_out[1]), 0);
        rd_loc(8'h05, 8'h3C, "R5 written byte");

        // R4 arm window expires
        put(2'd2, 8'h04);
        idle(ARW);
        chk("R3 arm expired", int'(ctrl_out[2]), 0);
        put(2'd2, 8'h02);
        chk("R4 late start ignored", int'(ctrl_out[1]), 0);

        // R4 both bits in one write
        put(2'd2, 8'h06);
        chk("R4 same-write start ignored", int'(ctrl_out[1]), 0);
        idle(ARW);

        // R7 R10 write to top location with interference
        put(2'd0, 8'h7F);
        put(2'd1, 8'hA5);
        put(2'd2, 8'h04);
        put(2'd2, 8'h02);
        put(2'd2, 8'h01);
        chk("R7 read during write bit", int'(ctrl_out[0]), 0);
        chk("R7 read during write data", int'(data_out), 8'hA5);
        put(2'd2, 8'h06);
        put(2'd2, 8'h02);
        chk("R10 still busy", int'(ctrl_out[1]), 1);
        idle(WRC);
        chk("R10 write ended on time", int'(ctrl_out[1]), 0);
        rd_loc(8'h7F, 8'hA5, "R9 top location written");
        chk("R6 read bit pulse", int'(ctrl_out[0]), 1);
        idle(1);
        chk("R6 read bit cleared", int'(ctrl_out[0]), 0);

        // R8 abort by data write
        put(2'd0, 8'h10);
        put(2'd1, 8'h11);
        put(2'd2, 8'h04);
        put(2'd2, 8'h02);
        idle(2);
        put(2'd1, 8'h22);
        chk("R8 abort clears busy", int'(ctrl_out[1]), 0);
        chk("R8 new data kept", int'(data_out), 8'h22);
        rd_loc(8'h10, 8'hFF, "R8 aborted location");

        // R8 abort by location write
        put(2'd0, 8'h20);
        put(2'd1, 8'h5A);
        put(2'd2, 8'h04);
        put(2'd2, 8'h02);
        put(2'd0, 8'h21);
        chk("R8 abort by location", int'(ctrl_out[1]), 0);
        chk("R8 new location kept", int'(addr_out), 8'h21);
        rd_loc(8'h20, 8'hFF, "R8 aborted location 2");

        // R2 reserved bits
        put(2'd2, 8'hF8);
        chk("R2 reserved read zero", int'(ctrl_out[7:3]), 0);
        idle(ARW + 1);
        finish_up();
    end

endmodule